// File: doc/BRIEF.md
# Consecutive-Zero Auto-Mute Controller

This block sits in a multi-channel DAC sample path and decides, frame by frame, whether each channel is silenced. Two things can silence a channel. The first is a software mute bit that belongs to that channel alone. The second is an optional automatic mute. It engages once the channel has delivered a long unbroken run of exactly-zero two's-complement samples, and it drops out on the first sample that is not zero.

A frame strobe marks each new set of samples. On a strobe the block advances every channel's zero-run counter. It then registers, for each channel, an effective mute flag and a gated sample. The gated sample is the input sample, or the zero code when the channel is muted. Between strobes both outputs hold their values. A global enable turns the automatic mute on or off for all channels. While the enable is low, every run counter is held at zero.

Top module: `zmute_ctrl`

## Requirements
- R1: While reset is high and after it is released, with no strobe yet seen, every mute flag reads 0 and every output sample reads 0.
- R2: Outputs change only on a clock edge where the frame strobe is high, and they are valid from the cycle after that edge. With no strobe, outputs hold even when the inputs change.
- R3: When a channel's manual mute bit is 1 at a strobe, that channel's mute flag is 1 and its output sample is all zeros for that frame. Other channels are not affected.
- R4: With the enable high, the frame carrying a channel's 512th consecutive zero sample is flagged muted. The frame carrying the 511th is not. A zero sample is the all-zeros code.
- R5: Further zero samples keep an auto-muted channel muted indefinitely. The run count saturates at 512 and never wraps.
- R6: A single non-zero sample, including the most negative code 0x8000 and 0xFFFF (minus one), ends the auto-mute. That same frame is output unmuted with its sample intact, and the zero run restarts from 0.
- R7: While the enable is low, no channel is auto-muted and all zero-run counters are held at 0. After the enable is raised again, a channel needs a fresh run of 512 zeros to auto-mute.
- R8: An unmuted channel outputs its input sample unchanged.
- R9: Channels are independent. Each has its own run counter and manual bit, and samples are packed with channel c at bits [c*16+15 : c*16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame of samples |
| smp_in | input | NCH*DW (64) | Packed per-channel two's-complement input samples |
| man_mute | input | NCH (4) | Per-channel manual mute bits |
| auto_en | input | 1 | Global enable for the consecutive-zero auto-mute |
| smp_out | output | NCH*DW (64) | Packed gated samples, zero when muted |
| mute_out | output | NCH (4) | Per-channel effective mute flags |

## Verification
Every result belongs to the frame whose strobe is sampled on a rising edge, and it appears one register later, just after that edge. The bench drives inputs on falling edges, raises the strobe for one cycle, and compares both outputs on the following falling edge against a per-channel run-count model. On the cycle after that it changes the inputs without a strobe and confirms that nothing moves. Directed runs place a frame exactly on the 511th and the 512th zero, and the release frames use extreme non-zero codes.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

    localparam int unsigned DEF_NCH     = 4;
    localparam int unsigned DEF_DW      = 16;
    localparam int unsigned DEF_RUN_LEN = 512;

    // Mute request gathered for one channel on one frame
    typedef struct packed {
        logic manual;    // software mute bit
        logic auto_en;   // global automatic-mute enable
        logic auto_hit;  // zero run has reached its limit on this frame
    } mute_req_t;

    function automatic logic mute_decide(input mute_req_t r);
        return r.manual | (r.auto_en & r.auto_hit);
    endfunction

endpackage

// File: rtl/zmute_run_counter.sv
module zmute_run_counter
    import zmute_pkg::*;
#(
    parameter int unsigned DW      = DEF_DW,
    parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          clr,
    input  logic [DW-1:0] sample,
    output logic          auto_hit
);
    localparam int unsigned CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic          is_zero;

    assign is_zero = (sample == '0);

    always_comb begin
        cnt_nx = cnt_q;
        if (clr) begin
            cnt_nx = '0;
        end else if (stb) begin
            if (!is_zero)          cnt_nx = '0;
            else if (cnt_q < FULL) cnt_nx = cnt_q + CW'(1);
            else                   cnt_nx = FULL;
        end
    end

    // The frame that completes the run is itself muted
    assign auto_hit = (cnt_nx == FULL);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nx;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

    p_nz_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && !is_zero) |=> (cnt_q == '0));

    p_zero_step_r4: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && is_zero && cnt_q < FULL) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    p_clr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/zmute_gate.sv
module zmute_gate
    import zmute_pkg::*;
#(
    parameter int unsigned DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [DW-1:0] sample,
    input  mute_req_t     req,
    output logic [DW-1:0] smp_out,
    output logic          mute_out
);
    logic muted;
    assign muted = mute_decide(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out  <= '0;
            mute_out <= 1'b0;
        end else if (stb) begin
            smp_out  <= muted ? '0 : sample;
            mute_out <= muted;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(smp_out) && $stable(mute_out)));

    p_manual_r3: assert property (@(posedge clk) disable iff (rst)
        (stb && req.manual) |=> (mute_out && smp_out == '0));

    p_no_auto_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (stb && !req.auto_en && !req.manual) |=> (!mute_out && smp_out == $past(sample)));

endmodule

// File: rtl/zmute_ctrl.sv
module zmute_ctrl
    import zmute_pkg::*;
#(
    parameter int unsigned NCH     = DEF_NCH,
    parameter int unsigned DW      = DEF_DW,
    parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [NCH*DW-1:0] smp_in,
    input  logic [NCH-1:0]    man_mute,
    input  logic              auto_en,
    output logic [NCH*DW-1:0] smp_out,
    output logic [NCH-1:0]    mute_out
);
    localparam int unsigned TOTAL_W = NCH * DW;

    logic clr_runs;
    assign clr_runs = ~auto_en;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] ch_smp;
        logic          ch_hit;
        mute_req_t     ch_req;

        assign ch_smp = smp_in[c*DW +: DW];
        assign ch_req = '{manual: man_mute[c], auto_en: auto_en, auto_hit: ch_hit};

        zmute_run_counter #(.DW(DW), .RUN_LEN(RUN_LEN)) u_run (
            .clk      (clk),
            .rst      (rst),
            .stb      (frame_stb),
            .clr      (clr_runs),
            .sample   (ch_smp),
            .auto_hit (ch_hit)
        );

        zmute_gate #(.DW(DW)) u_gate (
            .clk      (clk),
            .rst      (rst),
            .stb      (frame_stb),
            .sample   (ch_smp),
            .req      (ch_req),
            .smp_out  (smp_out[c*DW +: DW]),
            .mute_out (mute_out[c])
        );
    end

    p_muted_is_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_out & {TOTAL_W{1'b1}}) != '0 |-> (mute_out != {NCH{1'b1}}));

endmodule

// File: tb/tb_zmute_ctrl.sv
module tb_zmute_ctrl;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int RUN = 512;

    logic              clk = 1'b0;
    logic              rst;
    logic              frame_stb;
    logic [NCH*DW-1:0] smp_in;
    logic [NCH-1:0]    man_mute;
    logic              auto_en;
    logic [NCH*DW-1:0] smp_out;
    logic [NCH-1:0]    mute_out;

    int total = 0;
    int bad   = 0;
    int run_m [NCH];
    logic [NCH*DW-1:0] exp_s;
    logic [NCH-1:0]    exp_m;
    bit done = 0;

    always #10 clk = ~clk;

    zmute_ctrl #(.NCH(NCH), .DW(DW), .RUN_LEN(RUN)) dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .smp_in(smp_in),
        .man_mute(man_mute), .auto_en(auto_en), .smp_out(smp_out), .mute_out(mute_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one frame from the requirements
    task automatic model(input logic [NCH*DW-1:0] s, input logic [NCH-1:0] m, input logic en);
        for (int c = 0; c < NCH; c++) begin
            logic [DW-1:0] v;
            logic mu;
            v = s[c*DW +: DW];
            if (!en)            run_m[c] = 0;
            else if (v == '0)   run_m[c] = (run_m[c] < RUN) ? run_m[c] + 1 : RUN;
            else                run_m[c] = 0;
            mu = m[c] | (en & (run_m[c] >= RUN));
            exp_m[c] = mu;
            exp_s[c*DW +: DW] = mu ? '0 : v;
        end
    endtask

    task automatic frame(input logic [NCH*DW-1:0] s, input logic [NCH-1:0] m,
                         input logic en, input string tag);
        @(negedge clk);
        smp_in = s; man_mute = m; auto_en = en; frame_stb = 1'b1;
        model(s, m, en);
        @(negedge clk);
        frame_stb = 1'b0;
        check({tag, " mute"}, 64'(mute_out), 64'(exp_m));
        check({tag, " data"}, 64'(smp_out), 64'(exp_s));
    endtask

    function automatic logic [NCH*DW-1:0] put(input logic [NCH*DW-1:0] s, input int c,
                                               input logic [DW-1:0] v);
        logic [NCH*DW-1:0] r;
        r = s;
        r[c*DW +: DW] = v;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NCH*DW-1:0] s;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        for (int c = 0; c < NCH; c++) run_m[c] = 0;
        rst = 1'b1; frame_stb = 1'b0; smp_in = '0; man_mute = '0; auto_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset mute", 64'(mute_out), 64'd0);
        check("R1 reset data", 64'(smp_out), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 post-reset mute", 64'(mute_out), 64'd0);

        // R8/R9: plain pass-through with distinct values
        frame(64'h8000_FFFF_0001_7FFF, 4'b0000, 1'b1, "R8 pass");

        // R4/R5/R6 on channel 0, others non-zero
        s = 64'h1234_5678_9ABC_0000;
        for (int i = 1; i <= 510; i++) frame(s, 4'b0000, 1'b1, "R9 run");
        frame(s, 4'b0000, 1'b1, "R4 511th zero");
        check("R4 511th unmuted", 64'(mute_out[0]), 64'd0);
        frame(s, 4'b0000, 1'b1, "R4 512th zero");
        check("R4 512th muted", 64'(mute_out[0]), 64'd1);
        for (int i = 0; i < 30; i++) frame(s, 4'b0000, 1'b1, "R5 saturate");
        check("R5 still muted", 64'(mute_out[0]), 64'd1);
        frame(put(s, 0, 16'h8000), 4'b0000, 1'b1, "R6 release 8000");
        check("R6 release data", 64'(smp_out[15:0]), 64'h8000);

        // R2: inputs change without strobe, outputs hold
        @(negedge clk);
        smp_in = 64'hDEAD_BEEF_CAFE_F00D; man_mute = 4'b1111; auto_en = 1'b0;
        @(negedge clk);
        check("R2 hold mute", 64'(mute_out), 64'(exp_m));
        check("R2 hold data", 64'(smp_out), 64'(exp_s));

        // R3: manual mute on channel 2 only
        frame(64'h1111_2222_3333_4444, 4'b0100, 1'b1, "R3 manual");
        check("R3 ch2 zero", 64'(smp_out[47:32]), 64'd0);
        check("R3 ch1 intact", 64'(smp_out[31:16]), 64'h3333);

        // R7: enable low with long zero run, then fresh run needed
        s = 64'h0001_0001_0000_0001;
        for (int i = 0; i < 600; i++) frame(s, 4'b0000, 1'b0, "R7 disabled");
        check("R7 no auto mute", 64'(mute_out[1]), 64'd0);
        for (int i = 0; i < 511; i++) frame(s, 4'b0000, 1'b1, "R7 refill");
        check("R7 511 after enable", 64'(mute_out[1]), 64'd0);
        frame(s, 4'b0000, 1'b1, "R7 512 after enable");
        check("R7 muted after refill", 64'(mute_out[1]), 64'd1);
        frame(put(s, 1, 16'hFFFF), 4'b0000, 1'b1, "R6 release FFFF");
        frame(s, 4'b0000, 1'b0, "R7 drop enable");

        // Random mix: mostly zeros, occasional manual bits and enable drops
        for (int i = 0; i < 3000; i++) begin
            logic [NCH-1:0] m;
            logic en;
            for (int c = 0; c < NCH; c++)
                s[c*DW +: DW] = ($urandom % 8 == 0) ? DW'($urandom) : '0;
            m  = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
            en = ($urandom % 50 != 0);
            frame(s, m, en, "R9 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule